// File: doc/BRIEF.md
# Quadrature Correlator Template Phase Tracker

This block keeps a locally generated square-wave reference template aligned with a 1-bit digitized RF waveform. A phase counter that wraps at a programmable period produces the template. The block derives two references from that counter: an in-phase copy and a quadrature copy that lags it by a quarter period. Two agreement-counting correlators compare the incoming bit stream with these references. Each correlator counts how many of the last N samples matched its reference, and both restart on a shared window boundary.

At correct alignment the in-phase sum is at its peak and the quadrature sum is at its midpoint (zero correlation). At each window boundary a step controller compares the quadrature sum with that midpoint. If the sum is outside a programmable deadband, the controller advances or holds back the template by exactly one clock, in the direction that brings the sum back toward the midpoint. A lock flag rises after a programmable number of consecutive windows with no step, and it falls on the first step. One such block covers one I/Q pair of a larger correlator bank.

Top module: `quad_phase_tracker`

## Requirements
- R1: While reset is held, and on release, `phase` is 0, `iSum` and `qSum` are 0 and `locked` is 0.
- R2: With no pending step, `phase` rises by one on each clock and wraps from P-1 to 0, where P is `periodCfg` (P >= 4). It never leaves the range 0..P-1.
- R3: The in-phase reference is 1 when phase < floor(P/2). The quadrature reference is 1 when floor(P/4) <= phase < floor(P/4)+floor(P/2). A waveform equal to the quadrature reference gives qSum = N, and the inverted one gives qSum = 0.
- R4: Windows of N = `winLen` samples (N >= 2) run back to back from reset. On the clock that takes in a window's last sample, each sum is loaded with the number of samples in that window that equalled its reference. The sum then holds until the next window ends.
- R5: If the input equals the in-phase reference, N is a multiple of P and P is a multiple of 4, then a window gives iSum = N and qSum = N/2.
- R6: If a published qSum is greater than floor(N/2) + `deadband`, the phase holds its value (a retard step) on the second clock after publication.
- R7: If qSum + `deadband` is less than floor(N/2), the phase moves forward by two, modulo P (an advance step), on the second clock after publication.
- R8: A qSum inside the deadband causes no step, so the phase keeps counting freely.
- R9: `locked` rises on the clock after the publication that completes K = `lockWins` (K >= 1) consecutive step-free windows. It changes only on that clock after a publication.
- R10: `locked` falls on the clock after a publication that causes a step.
- R11: Starting from a phase offset of a few clocks, the tracker reaches exact alignment (iSum = N, qSum = N/2) and asserts `locked`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sampleBit | input | 1 | 1-bit digitized waveform sample |
| periodCfg | input | PER_W | Template period P in clocks (>= 4) |
| winLen | input | WIN_W | Correlation window length N in samples (>= 2) |
| deadband | input | WIN_W | Half-width of the no-step band around N/2 |
| lockWins | input | LOCK_W | Consecutive step-free windows needed for lock |
| phase | output | PER_W | Current template phase |
| iSum | output | WIN_W | Last in-phase agreement count |
| qSum | output | WIN_W | Last quadrature agreement count |
| locked | output | 1 | Lock indicator |

## Verification
The hardest situation to reach is a step that lands in the middle of a window. The window that follows is then a mix of two alignments, and the loop must not overshoot or oscillate because of it. The stimulus source is a square wave generated in the bench with a chosen starting offset. A mid-run jump of a quarter period forces steps from a locked state, and a non-multiple-of-four-aligned start offset forces a chain of steps. A behavioural model checks phase, both sums and lock on every clock, so the mixed windows are compared count for count.

// File: rtl/qpt_pkg.sv
package qpt_pkg;
  // Control-to-datapath step request, valid for one clock.
  typedef struct packed {
    logic adv;  // move template forward by one extra clock
    logic ret;  // hold template for one clock
  } step_strobe_t;
endpackage

// File: rtl/qpt_tpl_gen.sv
module qpt_tpl_gen
  import qpt_pkg::*;
#(
  parameter int PER_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [PER_W-1:0] periodCfg,
  input  step_strobe_t     strobe,
  output logic [PER_W-1:0] phase,
  output logic             refI,
  output logic             refQ
);
  localparam int EXT_W = PER_W + 1;

  logic [PER_W-1:0] halfP;
  logic [PER_W-1:0] quarterP;
  logic [1:0]       incr;
  logic [EXT_W-1:0] nxt;
  logic [EXT_W-1:0] wrapped;

  assign halfP    = periodCfg >> 1;
  assign quarterP = periodCfg >> 2;

  // A step changes the per-clock increment: 0 holds, 2 advances.
  always_comb begin
    if (strobe.adv)      incr = 2'd2;
    else if (strobe.ret) incr = 2'd0;
    else                 incr = 2'd1;
  end

  assign nxt     = {1'b0, phase} + {{(PER_W-1){1'b0}}, incr};
  assign wrapped = nxt - {1'b0, periodCfg};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      phase <= '0;
    end else if (phase >= periodCfg) begin
      phase <= '0;
    end else if (nxt >= {1'b0, periodCfg}) begin
      phase <= wrapped[PER_W-1:0];
    end else begin
      phase <= nxt[PER_W-1:0];
    end
  end

  assign refI = (phase < halfP);
  assign refQ = (phase >= quarterP) &&
                ({1'b0, phase} < ({1'b0, quarterP} + {1'b0, halfP}));
endmodule

// File: rtl/qpt_corr_lane.sv
module qpt_corr_lane #(
  parameter int WIN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sampleBit,
  input  logic             refBit,
  input  logic             winLast,
  output logic [WIN_W-1:0] sum
);
  logic             agree;
  logic [WIN_W-1:0] acc;
  logic [WIN_W-1:0] accNext;

  assign agree   = ~(sampleBit ^ refBit);
  assign accNext = acc + {{(WIN_W-1){1'b0}}, agree};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      acc <= '0;
      sum <= '0;
    end else if (winLast) begin
      sum <= accNext;
      acc <= '0;
    end else begin
      acc <= accNext;
    end
  end
endmodule

// File: rtl/qpt_datapath.sv
module qpt_datapath
  import qpt_pkg::*;
#(
  parameter int PER_W = 8,
  parameter int WIN_W = 10
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sampleBit,
  input  logic [PER_W-1:0] periodCfg,
  input  logic [WIN_W-1:0] winLen,
  input  step_strobe_t     strobe,
  output logic [PER_W-1:0] phase,
  output logic [WIN_W-1:0] iSum,
  output logic [WIN_W-1:0] qSum,
  output logic             winDone
);
  localparam int LANES = 2;  // lane 0 in-phase, lane 1 quadrature

  logic             refBits [LANES];
  logic [WIN_W-1:0] laneSum [LANES];
  logic [WIN_W-1:0] winCnt;
  logic             winLast;

  qpt_tpl_gen #(.PER_W(PER_W)) tpl_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .periodCfg (periodCfg),
    .strobe    (strobe),
    .phase     (phase),
    .refI      (refBits[0]),
    .refQ      (refBits[1])
  );

  assign winLast = (({1'b0, winCnt} + {{WIN_W{1'b0}}, 1'b1}) >= {1'b0, winLen});

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      winCnt  <= '0;
      winDone <= 1'b0;
    end else if (winLast) begin
      winCnt  <= '0;
      winDone <= 1'b1;
    end else begin
      winCnt  <= winCnt + 1'b1;
      winDone <= 1'b0;
    end
  end

  for (genvar g = 0; g < LANES; g++) begin : g_lane
    qpt_corr_lane #(.WIN_W(WIN_W)) lane_i (
      .clk       (clk),
      .rst_n     (rst_n),
      .sampleBit (sampleBit),
      .refBit    (refBits[g]),
      .winLast   (winLast),
      .sum       (laneSum[g])
    );
  end

  assign iSum = laneSum[0];
  assign qSum = laneSum[1];
endmodule

// File: rtl/qpt_step_ctrl.sv
module qpt_step_ctrl
  import qpt_pkg::*;
#(
  parameter int WIN_W  = 10,
  parameter int LOCK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              winDone,
  input  logic [WIN_W-1:0]  qSum,
  input  logic [WIN_W-1:0]  winLen,
  input  logic [WIN_W-1:0]  deadband,
  input  logic [LOCK_W-1:0] lockWins,
  output step_strobe_t      strobe,
  output logic              locked
);
  logic [WIN_W-1:0]  midPt;
  logic [WIN_W:0]    upperEdge;
  logic [WIN_W:0]    qPlusBand;
  logic              wantRet;
  logic              wantAdv;
  logic [LOCK_W-1:0] cleanCnt;
  logic [LOCK_W:0]   cleanNext;

  assign midPt     = winLen >> 1;
  assign upperEdge = {1'b0, midPt} + {1'b0, deadband};
  assign qPlusBand = {1'b0, qSum} + {1'b0, deadband};
  assign wantRet   = ({1'b0, qSum} > upperEdge);
  assign wantAdv   = (qPlusBand < {1'b0, midPt});
  assign cleanNext = {1'b0, cleanCnt} + {{LOCK_W{1'b0}}, 1'b1};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe   <= '0;
      locked   <= 1'b0;
      cleanCnt <= '0;
    end else begin
      strobe.adv <= winDone && wantAdv;
      strobe.ret <= winDone && wantRet;
      if (winDone) begin
        if (wantAdv || wantRet) begin
          cleanCnt <= '0;
          locked   <= 1'b0;
        end else begin
          if (cleanCnt < lockWins) cleanCnt <= cleanNext[LOCK_W-1:0];
          locked <= (cleanNext >= {1'b0, lockWins});
        end
      end
    end
  end
endmodule

// File: rtl/quad_phase_tracker.sv
module quad_phase_tracker
  import qpt_pkg::*;
#(
  parameter int PER_W  = 8,
  parameter int WIN_W  = 10,
  parameter int LOCK_W = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              sampleBit,
  input  logic [PER_W-1:0]  periodCfg,
  input  logic [WIN_W-1:0]  winLen,
  input  logic [WIN_W-1:0]  deadband,
  input  logic [LOCK_W-1:0] lockWins,
  output logic [PER_W-1:0]  phase,
  output logic [WIN_W-1:0]  iSum,
  output logic [WIN_W-1:0]  qSum,
  output logic              locked
);
  step_strobe_t ctlStr;
  logic         winDone;

  qpt_datapath #(.PER_W(PER_W), .WIN_W(WIN_W)) dp_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .sampleBit (sampleBit),
    .periodCfg (periodCfg),
    .winLen    (winLen),
    .strobe    (ctlStr),
    .phase     (phase),
    .iSum      (iSum),
    .qSum      (qSum),
    .winDone   (winDone)
  );

  qpt_step_ctrl #(.WIN_W(WIN_W), .LOCK_W(LOCK_W)) ctl_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .winDone  (winDone),
    .qSum     (qSum),
    .winLen   (winLen),
    .deadband (deadband),
    .lockWins (lockWins),
    .strobe   (ctlStr),
    .locked   (locked)
  );
endmodule

// File: rtl/qpt_checker.sv
module qpt_checker #(
  parameter int PER_W = 8,
  parameter int WIN_W = 10
) (
  input logic             clk,
  input logic             rst_n,
  input logic [PER_W-1:0] periodCfg,
  input logic [WIN_W-1:0] winLen,
  input logic [WIN_W-1:0] deadband,
  input logic [PER_W-1:0] phase,
  input logic [WIN_W-1:0] iSum,
  input logic [WIN_W-1:0] qSum,
  input logic             locked,
  input logic             winDone,
  input logic             stepAdv,
  input logic             stepRet
);
  // R2
  phase_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(periodCfg) && periodCfg >= 4) |-> (phase < periodCfg));

  // R2
  phase_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($stable(periodCfg) && periodCfg >= 4 && $past(phase) < periodCfg) |->
      ((int'(phase) == (int'($past(phase)) + 1) % int'(periodCfg)) ||
       (phase == $past(phase)) ||
       (int'(phase) == (int'($past(phase)) + 2) % int'(periodCfg))));

  // R4
  sum_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $stable(winLen) |-> (iSum <= winLen && qSum <= winLen));

  // R6
  ret_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepRet |-> ($past(winDone) &&
      int'($past(qSum)) > int'($past(winLen) >> 1) + int'($past(deadband))));

  // R7
  adv_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    stepAdv |-> ($past(winDone) &&
      int'($past(qSum)) + int'($past(deadband)) < int'($past(winLen) >> 1)));

  // R9
  lock_rise_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(locked) |-> $past(winDone));

  // R10
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(locked) |-> (stepAdv || stepRet));
endmodule

bind quad_phase_tracker qpt_checker #(.PER_W(PER_W), .WIN_W(WIN_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .periodCfg (periodCfg),
  .winLen    (winLen),
  .deadband  (deadband),
  .phase     (phase),
  .iSum      (iSum),
  .qSum      (qSum),
  .locked    (locked),
  .winDone   (winDone),
  .stepAdv   (ctlStr.adv),
  .stepRet   (ctlStr.ret)
);

// File: tb/quad_phase_tracker_tb_top.sv
module quad_phase_tracker_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int PER_W  = 8;
  localparam int WIN_W  = 10;
  localparam int LOCK_W = 4;

  logic              clk = 1'b0;
  logic              rst_n = 1'b0;
  logic              sampleBit = 1'b0;
  logic [PER_W-1:0]  periodCfg = 8'd16;
  logic [WIN_W-1:0]  winLen = 10'd64;
  logic [WIN_W-1:0]  deadband = 10'd2;
  logic [LOCK_W-1:0] lockWins = 4'd3;
  logic [PER_W-1:0]  phase;
  logic [WIN_W-1:0]  iSum;
  logic [WIN_W-1:0]  qSum;
  logic              locked;

  int checkCnt = 0;
  int failCnt  = 0;
  int cfgP = 16, cfgN = 64, cfgDb = 2, cfgK = 3;
  int srcPh = 0;

  // reference model state
  int mPh, mCnt, mIa, mQa, mIs, mQs, mClean;
  bit mDone, mAdv, mRet, mLock;

  always #(CLK_PERIOD/2) clk = ~clk;

  quad_phase_tracker #(.PER_W(PER_W), .WIN_W(WIN_W), .LOCK_W(LOCK_W)) dut_i (
    .clk(clk), .rst_n(rst_n), .sampleBit(sampleBit), .periodCfg(periodCfg),
    .winLen(winLen), .deadband(deadband), .lockWins(lockWins),
    .phase(phase), .iSum(iSum), .qSum(qSum), .locked(locked)
  );

  // Behavioural model advanced on each rising edge from the pre-edge state.
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mPh = 0; mCnt = 0; mIa = 0; mQa = 0; mIs = 0; mQs = 0; mClean = 0;
      mDone = 0; mAdv = 0; mRet = 0; mLock = 0;
    end else begin
      int newPh, aI, aQ, midV;
      bit wantA, wantR, refIv, refQv, newDone;
      midV  = cfgN / 2;
      wantR = mDone && (mQs > midV + cfgDb);
      wantA = mDone && (mQs + cfgDb < midV);
      if (mDone) begin
        if (wantA || wantR) begin mClean = 0; mLock = 0; end
        else begin mClean = mClean + 1; mLock = (mClean >= cfgK); end
      end
      newPh = (mPh + (mAdv ? 2 : (mRet ? 0 : 1))) % cfgP;
      refIv = (mPh < cfgP / 2);
      refQv = (mPh >= cfgP / 4) && (mPh < cfgP / 4 + cfgP / 2);
      aI = (sampleBit == refIv) ? 1 : 0;
      aQ = (sampleBit == refQv) ? 1 : 0;
      if (mCnt == cfgN - 1) begin
        mIs = mIa + aI; mQs = mQa + aQ; mIa = 0; mQa = 0; mCnt = 0; newDone = 1;
      end else begin
        mIa = mIa + aI; mQa = mQa + aQ; mCnt = mCnt + 1; newDone = 0;
      end
      mDone = newDone;
      mAdv  = wantA;
      mRet  = wantR;
      mPh   = newPh;
    end
  end

  task automatic check(input bit ok, input string tag, input int act, input int exp);
    checkCnt++;
    if (!ok) begin
      failCnt++;
      $display("FAIL %s actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic compareModel();
    check(int'(phase) == mPh, "R2 phase vs model", int'(phase), mPh);
    check(int'(iSum) == mIs, "R4 iSum vs model", int'(iSum), mIs);
    check(int'(qSum) == mQs, "R4 qSum vs model", int'(qSum), mQs);
    check(locked == mLock, "R9 locked vs model", int'(locked), int'(mLock));
  endtask

  function automatic bit srcBit(input int ph);
    return (ph < cfgP / 2);
  endfunction

  // One clock: compare after the edge, then drive the next sample.
  task automatic tick(input int n, input int jump = 0);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compareModel();
      srcPh = (srcPh + 1 + ((i == 0) ? jump : 0)) % cfgP;
      sampleBit = srcBit(srcPh);
    end
  endtask

  task automatic startRun(input int p, input int nw, input int db, input int k, input int off);
    @(negedge clk);
    rst_n = 1'b0;
    cfgP = p; cfgN = nw; cfgDb = db; cfgK = k;
    periodCfg = PER_W'(p); winLen = WIN_W'(nw);
    deadband = WIN_W'(db); lockWins = LOCK_W'(k);
    srcPh = off % p;
    sampleBit = srcBit(srcPh);
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    failCnt++;
    $display("FAIL R11 watchdog expired actual=%0d expected=%0d", 150000, 0);
    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end

  initial begin
    int p1, p2;
    // Aligned source.
    startRun(16, 64, 2, 3, 0);
    check(phase == 0, "R1 phase after reset", int'(phase), 0);
    check(iSum == 0, "R1 iSum after reset", int'(iSum), 0);
    check(qSum == 0, "R1 qSum after reset", int'(qSum), 0);
    check(locked == 0, "R1 locked after reset", int'(locked), 0);
    tick(64);
    check(iSum == 64, "R5 aligned iSum", int'(iSum), 64);
    check(qSum == 32, "R5 aligned qSum", int'(qSum), 32);
    tick(128);
    check(int'(phase) == (192 % 16), "R2 free count", int'(phase), 192 % 16);
    check(locked == 0, "R9 not before K windows", int'(locked), 0);
    tick(1);
    check(locked == 1, "R9 lock after K windows", int'(locked), 1);
    // Quarter-period disturbance.
    tick(2 * 64 + 2, 4);
    check(locked == 0, "R10 lock drop on step", int'(locked), 0);
    tick(64 * 12);

    // Source equal to the quadrature reference: retard.
    startRun(16, 64, 2, 3, 12);
    tick(64);
    check(qSum == 64, "R3 quadrature full agreement", int'(qSum), 64);
    check(iSum == 32, "R3 in-phase half agreement", int'(iSum), 32);
    tick(1); p1 = int'(phase);
    tick(1); p2 = int'(phase);
    check(p2 == p1, "R6 retard holds phase", p2, p1);
    tick(64 * 12);

    // Inverted quadrature: advance.
    startRun(16, 64, 2, 3, 4);
    tick(64);
    check(qSum == 0, "R3 quadrature zero agreement", int'(qSum), 0);
    tick(1); p1 = int'(phase);
    tick(1); p2 = int'(phase);
    check(p2 == (p1 + 2) % 16, "R7 advance by two", p2, (p1 + 2) % 16);
    tick(64 * 12);

    // Offset inside a wide deadband: no step.
    startRun(16, 64, 8, 3, 1);
    tick(64 * 5);
    check(int'(phase) == (320 % 16), "R8 no step in deadband", int'(phase), 320 % 16);
    check(qSum == 24, "R8 quadrature sum inside band", int'(qSum), 24);
    check(locked == 1, "R9 lock with deadband", int'(locked), 1);

    // Non-power-of-two period, offset start: convergence.
    startRun(12, 48, 2, 2, 2);
    tick(48 * 20);
    check(locked == 1, "R11 converged lock", int'(locked), 1);
    check(iSum == 48, "R11 converged iSum", int'(iSum), 48);
    check(qSum == 24, "R11 converged qSum", int'(qSum), 24);

    $display("End of test - %0d assertions evaluated, %0d failures", checkCnt, failCnt);
    $finish;
  end
endmodule